// File: doc/BRIEF.md
# Clock Synthesizer Configuration Bridge

This block sits between a host register bus and the 16-bit configuration port of an on-chip clock synthesizer. The host sees four 32-bit word registers. One register holds the block and synthesizer enable bits. One holds the reference-source index. One is a control word whose single write starts a complete port access. The last is a status word that reports a busy flag and the data returned by the most recent port read.

Software writes the control word with the start bit set. It then polls the status word until busy drops. For a read access it takes the 16-bit result from the low half of the same status word. A control write made while an access is still in flight is dropped, so the access in progress cannot be disturbed. Host reads are combinational: `reg_rdata` reflects the addressed register while `reg_rd` is high and is zero otherwise.

Top module: `cfgport_bridge`

## Requirements
- R1: After a synchronous reset every register reads zero, busy is low, and `blk_en`, `synth_en`, `src_sel` and `cp_en` are all low.
- R2: A write to byte offset 0x40 (word 0x10) stores bits [1:0]. Bit 0 drives `blk_en` and bit 1 drives `synth_en`, which keeps the synthesizer disabled while it is clear. The register reads back those two bits with all other bits zero.
- R3: A write to byte offset 0x44 (word 0x11) stores bit 0 as `src_sel`. The register reads back only that bit, so any higher bits that were written read as zero.
- R4: A write to byte offset 0x70 (word 0x1C) made while idle, with bit 29 set, raises `cp_en` for exactly one cycle, starting in the cycle after the write. In that cycle `cp_we` is the inverse of bit 28, `cp_addr` carries bits [22:16] and `cp_wdata` carries bits [15:0].
- R5: Status bit 16 (offset 0x74, word 0x1D) is high from the cycle after a launch. It clears in the cycle after the clock edge at which `cp_ready` is sampled high.
- R6: A control write made while busy is ignored. No new access starts, and the control register keeps its earlier value.
- R7: When a read access completes, the `cp_rdata` value present with `cp_ready` is captured into status bits [15:0].
- R8: Status bits [15:0] change only when a read access completes. A completed write access leaves them unchanged.
- R9: A control write with bit 29 clear starts no access. It still updates the control register, which reads back bits 29, 28, [22:16] and [15:0] and returns zero in all other bits.
- R10: A `cp_ready` pulse while idle has no effect on busy or on the status data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | REG_AW | Host word address (byte offset / 4) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational |
| blk_en | output | 1 | Block enable (bit 0 of the enable register) |
| synth_en | output | 1 | Synthesizer enable (bit 1 of the enable register) |
| src_sel | output | SEL_W | Reference source index |
| cp_en | output | 1 | Configuration port access strobe, one cycle |
| cp_we | output | 1 | Access is a write |
| cp_addr | output | 7 | Configuration port address |
| cp_wdata | output | 16 | Configuration port write data |
| cp_rdata | input | 16 | Configuration port read data, valid with ready |
| cp_ready | input | 1 | Access completion from the synthesizer |

## Verification
The engine assertions assume that the synthesizer raises `cp_ready` for a single cycle per access, and only after `cp_en` has been seen, apart from deliberate stray pulses while idle. They also assume that `cp_rdata` is meaningful only in the ready cycle. The bench's synthesizer model follows these rules. It answers every strobe exactly once after a latency of zero to three cycles, and it injects one stray ready pulse only while the block is idle. Host strobes are applied one at a time. Control writes issued during busy are placed deliberately inside an access, so that the drop rule is exercised at a known cycle.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int HOST_DW = 32;
    localparam int CP_AW   = 7;
    localparam int CP_DW   = 16;

    // Byte offsets of the host registers
    localparam int BYTE_ENABLES = 32'h40;
    localparam int BYTE_SRCSEL  = 32'h44;
    localparam int BYTE_CTRL    = 32'h70;
    localparam int BYTE_STATUS  = 32'h74;

    // Control word fields
    localparam int CTRL_GO_BIT   = 29;
    localparam int CTRL_RD_BIT   = 28;
    localparam int CTRL_ADDR_LSB = 16;
    localparam int STAT_BUSY_BIT = 16;

    localparam logic [HOST_DW-1:0] CTRL_KEEP_MASK =
        (HOST_DW'(1) << CTRL_GO_BIT) | (HOST_DW'(1) << CTRL_RD_BIT) |
        (HOST_DW'((1 << CP_AW) - 1) << CTRL_ADDR_LSB) | HOST_DW'((1 << CP_DW) - 1);

    typedef struct packed {
        logic             we;
        logic [CP_AW-1:0] addr;
        logic [CP_DW-1:0] data;
    } cp_req_t;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ISSUE = 2'd1,
        ENG_WAIT  = 2'd2
    } eng_state_t;

    function automatic cp_req_t unpack_ctrl(input logic [HOST_DW-1:0] w);
        cp_req_t r;
        r.we   = ~w[CTRL_RD_BIT];
        r.addr = w[CTRL_ADDR_LSB +: CP_AW];
        r.data = w[CP_DW-1:0];
        return r;
    endfunction

    function automatic logic [HOST_DW-1:0] pack_status(input logic busy,
                                                       input logic [CP_DW-1:0] d);
        logic [HOST_DW-1:0] s;
        s = '0;
        s[STAT_BUSY_BIT] = busy;
        s[CP_DW-1:0]     = d;
        return s;
    endfunction

endpackage

// File: rtl/cfgport_regs.sv
module cfgport_regs
    import cfgport_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int SEL_W  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [HOST_DW-1:0] reg_wdata,
    output logic [HOST_DW-1:0] reg_rdata,
    input  logic               eng_busy,
    input  logic [CP_DW-1:0]   eng_rdata,
    output logic               launch,
    output cp_req_t            launch_req,
    output logic               blk_en,
    output logic               synth_en,
    output logic [SEL_W-1:0]   src_sel
);

    localparam logic [REG_AW-1:0] A_ENABLES = REG_AW'(BYTE_ENABLES >> 2);
    localparam logic [REG_AW-1:0] A_SRCSEL  = REG_AW'(BYTE_SRCSEL >> 2);
    localparam logic [REG_AW-1:0] A_CTRL    = REG_AW'(BYTE_CTRL >> 2);
    localparam logic [REG_AW-1:0] A_STATUS  = REG_AW'(BYTE_STATUS >> 2);

    logic [1:0]         en_q;
    logic [SEL_W-1:0]   sel_q;
    logic [HOST_DW-1:0] ctrl_q;
    logic               hit_en, hit_sel, hit_ctrl, ctrl_take;

    assign hit_en    = reg_wr && (reg_addr == A_ENABLES);
    assign hit_sel   = reg_wr && (reg_addr == A_SRCSEL);
    assign hit_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign ctrl_take = hit_ctrl && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            sel_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (hit_en)    en_q   <= reg_wdata[1:0];
            if (hit_sel)   sel_q  <= reg_wdata[SEL_W-1:0];
            if (ctrl_take) ctrl_q <= reg_wdata & CTRL_KEEP_MASK;
        end
    end

    assign launch     = ctrl_take && reg_wdata[CTRL_GO_BIT];
    assign launch_req = unpack_ctrl(reg_wdata);
    assign blk_en     = en_q[0];
    assign synth_en   = en_q[1];
    assign src_sel    = sel_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_ENABLES: reg_rdata = HOST_DW'(en_q);
                A_SRCSEL:  reg_rdata = HOST_DW'(sel_q);
                A_CTRL:    reg_rdata = ctrl_q;
                A_STATUS:  reg_rdata = pack_status(eng_busy, eng_rdata);
                default:   reg_rdata = '0;
            endcase
        end
    end

    // R6: a control write during an access leaves the stored word alone
    assert_ctrl_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        (eng_busy && hit_ctrl) |=> $stable(ctrl_q));

    // R3: the source index follows the last write
    assert_srcsel_follows_R3: assert property (@(posedge clk) disable iff (rst)
        hit_sel |=> (src_sel == $past(reg_wdata[SEL_W-1:0])));

endmodule

// File: rtl/cfgport_engine.sv
module cfgport_engine
    import cfgport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  cp_req_t          launch_req,
    input  logic             cp_ready,
    input  logic [CP_DW-1:0] cp_rdata,
    output logic             cp_en,
    output logic             cp_we,
    output logic [CP_AW-1:0] cp_addr,
    output logic [CP_DW-1:0] cp_wdata,
    output logic             busy,
    output logic [CP_DW-1:0] rd_data
);

    eng_state_t       state_q;
    cp_req_t          req_q;
    logic [CP_DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            req_q   <= '0;
            rd_q    <= '0;
        end else begin
            case (state_q)
                ENG_IDLE: begin
                    if (launch) begin
                        state_q <= ENG_ISSUE;
                        req_q   <= launch_req;
                    end
                end
                ENG_ISSUE, ENG_WAIT: begin
                    if (cp_ready) begin
                        state_q <= ENG_IDLE;
                        if (!req_q.we) rd_q <= cp_rdata;
                    end else begin
                        state_q <= ENG_WAIT;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    assign cp_en    = (state_q == ENG_ISSUE);
    assign cp_we    = req_q.we;
    assign cp_addr  = req_q.addr;
    assign cp_wdata = req_q.data;
    assign busy     = (state_q != ENG_IDLE);
    assign rd_data  = rd_q;

    // R4: a launch yields a port strobe on the next cycle, lasting one cycle
    assert_launch_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        launch |=> (cp_en && busy));
    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        cp_en |=> !cp_en);

    // R5: ready during an access ends it
    assert_busy_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && cp_ready) |=> !busy);

    // R7: a finishing read captures the port data
    assert_read_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && cp_ready && !cp_we) |=> (rd_data == $past(cp_rdata)));

    // R8: outside a finishing read, the captured data holds
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(busy && cp_ready && !cp_we) |=> $stable(rd_data));

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgport_pkg::*;
#(
    parameter int REG_AW = 6,
    parameter int SEL_W  = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [HOST_DW-1:0] reg_wdata,
    output logic [HOST_DW-1:0] reg_rdata,
    output logic               blk_en,
    output logic               synth_en,
    output logic [SEL_W-1:0]   src_sel,
    output logic               cp_en,
    output logic               cp_we,
    output logic [CP_AW-1:0]   cp_addr,
    output logic [CP_DW-1:0]   cp_wdata,
    input  logic [CP_DW-1:0]   cp_rdata,
    input  logic               cp_ready
);

    logic             eng_busy;
    logic [CP_DW-1:0] eng_rdata;
    logic             launch;
    cp_req_t          launch_req;

    cfgport_regs #(
        .REG_AW (REG_AW),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .eng_busy   (eng_busy),
        .eng_rdata  (eng_rdata),
        .launch     (launch),
        .launch_req (launch_req),
        .blk_en     (blk_en),
        .synth_en   (synth_en),
        .src_sel    (src_sel)
    );

    cfgport_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .launch_req (launch_req),
        .cp_ready   (cp_ready),
        .cp_rdata   (cp_rdata),
        .cp_en      (cp_en),
        .cp_we      (cp_we),
        .cp_addr    (cp_addr),
        .cp_wdata   (cp_wdata),
        .busy       (eng_busy),
        .rd_data    (eng_rdata)
    );

    // R1: out of reset nothing is strobed on the port
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!cp_en && !blk_en && !synth_en));

endmodule

// File: tb/test_cfgport_bridge.sv
module test_cfgport_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b1;
    logic [5:0]  reg_addr = 6'h1D;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        blk_en, synth_en;
    logic [0:0]  src_sel;
    logic        cp_en, cp_we;
    logic [6:0]  cp_addr;
    logic [15:0] cp_wdata;
    logic [15:0] cp_rdata = '0;
    logic        cp_ready = 1'b0;

    always #2 clk = ~clk;

    cfgport_bridge i_cfgport_bridge (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .blk_en(blk_en),
        .synth_en(synth_en), .src_sel(src_sel), .cp_en(cp_en), .cp_we(cp_we),
        .cp_addr(cp_addr), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_ready(cp_ready)
    );

    // reference model state
    int unsigned m_en, m_sel, m_ctrl, m_busy, m_issue, m_we, m_addr, m_wdata, m_data;
    int nchk = 0, nfail = 0;
    int resp_cnt = -1;
    int resp_lat = 1;
    string tag_override = "";

    function automatic int unsigned synth_reply(int unsigned a);
        return (16'hA5C3 ^ (a * 16'h0101) ^ (a << 9)) & 16'hFFFF;
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unsigned exp_rdata();
        if (!reg_rd) return 0;
        case (reg_addr)
            6'h10: return m_en;
            6'h11: return m_sel;
            6'h1C: return m_ctrl;
            6'h1D: return (m_busy << 16) | m_data;
            default: return 0;
        endcase
    endfunction

    function automatic string addr_tag();
        if (tag_override != "") return tag_override;
        case (reg_addr)
            6'h10: return "R2";
            6'h11: return "R3";
            6'h1C: return "R6";
            default: return "R7";
        endcase
    endfunction

    // one clock: model update at the edge, compare at the falling edge, then respond
    task automatic cycle();
        int unsigned old_busy;
        @(posedge clk);
        old_busy = m_busy;
        m_issue = 0;
        if (rst) begin
            m_en = 0; m_sel = 0; m_ctrl = 0; m_busy = 0; m_data = 0;
            m_we = 0; m_addr = 0; m_wdata = 0;
        end else begin
            if (old_busy != 0 && cp_ready) begin
                m_busy = 0;
                if (m_we == 0) m_data = cp_rdata;
            end
            if (reg_wr && reg_addr == 6'h10) m_en = reg_wdata & 3;
            if (reg_wr && reg_addr == 6'h11) m_sel = reg_wdata & 1;
            if (reg_wr && reg_addr == 6'h1C && old_busy == 0) begin
                m_ctrl = reg_wdata & 32'h307F_FFFF;
                if (reg_wdata[29]) begin
                    m_busy = 1; m_issue = 1;
                    m_we = reg_wdata[28] ? 0 : 1;
                    m_addr = (reg_wdata >> 16) & 7'h7F;
                    m_wdata = reg_wdata & 16'hFFFF;
                end
            end
        end
        @(negedge clk);
        if (!rst) begin
            check("R4 cp_en", cp_en, m_issue);
            if (m_issue != 0) begin
                check("R4 cp_we", cp_we, m_we);
                check("R4 cp_addr", cp_addr, m_addr);
                check("R4 cp_wdata", cp_wdata, m_wdata);
            end
            check("R2 enables", {synth_en, blk_en}, m_en);
            check("R3 src_sel", src_sel, m_sel);
            check(addr_tag(), reg_rdata, exp_rdata());
        end
        // synthesizer model
        if (cp_ready) cp_ready = 1'b0;
        if (m_issue != 0) resp_cnt = resp_lat;
        if (resp_cnt == 0) begin
            cp_ready = 1'b1;
            cp_rdata = 16'(synth_reply(m_addr));
            resp_cnt = -1;
        end else if (resp_cnt > 0) begin
            resp_cnt--;
        end
    endtask

    task automatic host_write(logic [5:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cycle();
        reg_wr = 1'b0; reg_addr = 6'h1D; reg_wdata = '0;
    endtask

    task automatic host_read(logic [5:0] a);
        reg_rd = 1'b1; reg_addr = a;
        cycle();
        reg_addr = 6'h1D;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && (m_busy != 0 || resp_cnt >= 0 || cp_ready); i++) cycle();
        cycle();
    endtask

    task automatic launch_access(bit rd, int unsigned a, int unsigned d, int lat);
        resp_lat = lat;
        host_write(6'h1C, (32'h1 << 29) | (32'(rd) << 28) | ((a & 7'h7F) << 16) | (d & 16'hFFFF));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) cycle();
        rst = 1'b0;
        // R1: reset values
        tag_override = "R1";
        host_read(6'h10); host_read(6'h11); host_read(6'h1C); host_read(6'h1D);
        tag_override = "";

        // R2: enable bits
        host_write(6'h10, 32'hFFFF_FFFF); host_read(6'h10);
        host_write(6'h10, 32'h2); host_read(6'h10);
        host_write(6'h10, 32'h1); host_read(6'h10);
        // R3: source select, upper bits dropped
        host_write(6'h11, 32'hFFFF_FFFE); host_read(6'h11);
        host_write(6'h11, 32'h0000_0003); host_read(6'h11);

        // R9: control word without the start bit
        host_write(6'h1C, 32'hDF92_ABCD); host_read(6'h1C); cycle();

        // R4/R8: port write, status data stays zero
        launch_access(0, 7'h28, 16'h9800, 2); wait_idle();
        // R7: port read, immediate ready
        launch_access(1, 7'h15, 16'h0000, 0); wait_idle();
        // R8: write after read leaves captured data
        launch_access(0, 7'h4E, 16'h1234, 3); wait_idle();

        // R6: control writes during an access are dropped
        launch_access(1, 7'h08, 16'h0, 3);
        host_write(6'h1C, 32'h2000_7777);
        host_write(6'h1C, 32'h3019_0000);
        wait_idle();
        host_read(6'h1C);

        // R10: stray ready while idle
        cp_rdata = 16'hDEAD; cp_ready = 1'b1;
        cycle(); cycle();

        // R4/R5/R7: mixed sequence
        for (int k = 0; k < 12; k++) begin
            launch_access(k % 3 == 0 ? 0 : 1, (k * 11 + 3) & 7'h7F, k * 16'h1111, k % 4);
            wait_idle();
        end

        // R2: clearing the synthesizer enable
        host_write(6'h10, 32'h0); host_read(6'h10);
        cycle();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule